// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block takes in serial words from an external master over a two-wire synchronous link: a clock input driven by the master and a data input. Each bit is captured on the active edge of the master's clock and shifted into an internal register, least significant bit first. When the last bit of a word arrives, the word moves into a holding register and a receive-complete flag goes high. The flag stays high until the host reads the holding register.

Words are 8 or 9 bits long. In 9-bit mode the ninth bit is the last one shifted in, and it goes to a separate status output. The low 8 bits go to the holding register. Reception runs only when all of these are set:
- the port enable,
- synchronous mode,
- slave clocking (clock taken from outside),
- the continuous-receive enable.

A single-shot receive control exists on the port list but has no effect in slave mode.

If a word finishes while the previous word is still unread, the block raises an overrun error. It discards the new word and stops shifting. Only clearing the continuous-receive enable clears the error, and doing so also realigns the bit counter. An interrupt request follows the receive-complete flag when the interrupt enable is set. While the system is in a low-power state, that request also drives a wake output.

Top module: `sync_slave_rx`

## Requirements
- R1: A word is received only while `port_en`, `sync_mode`, `clk_slave` and `cont_en` are all 1. While any of them is 0, `data_o` and `done_o` are not changed by serial activity, and the bit counter is held at zero.
- R2: `single_en` has no effect in slave mode. With `cont_en`=1 a word is received whatever `single_en` does. With `cont_en`=0 and `single_en`=1, nothing is received.
- R3: With `nine_bit`=0, eight bits are received least significant first on rising edges of `sck`. On the eighth bit, `data_o` takes the word, `done_o` goes to 1, and `ninth_o` goes to 0.
- R4: With `nine_bit`=1, nine bits are received. `data_o` takes the first eight bits (first bit at bit 0), and `ninth_o` takes the ninth bit.
- R5: A one-cycle pulse on `rd_data` clears `done_o` at the next clock edge.
- R6: `irq_o` is 1 exactly when `done_o` and `rx_ie` are both 1.
- R7: Reception continues while `low_power`=1. `wake_o` is 1 when `low_power`, `done_o` and `rx_ie` are all 1.
- R8: If a word completes while `done_o` is 1 and no read occurs in that cycle, `ovr_o` goes to 1 and `data_o` keeps the old word. Further serial edges are then ignored until the error is cleared.
- R9: `cont_en`=0 clears `ovr_o` at the next clock edge, leaves `done_o` unchanged, and resets the bit counter. The next word therefore starts at bit 0.
- R10: After reset, `data_o`=0, `done_o`=0, `ovr_o`=0, `irq_o`=0 and `wake_o`=0.
- R11: `done_o` and `data_o` update on the third system clock edge after the active `sck` edge. Two of those edges are spent in the synchroniser and one in the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_slave | input | 1 | 1: clock taken from the master |
| cont_en | input | 1 | Continuous-receive enable; 0 clears overrun |
| single_en | input | 1 | Single-shot receive control (ignored in slave mode) |
| nine_bit | input | 1 | 1: 9-bit words |
| rx_ie | input | 1 | Receive interrupt enable |
| low_power | input | 1 | System is in a low-power or idle state |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data |
| rd_data | input | 1 | Read strobe for the holding register |
| data_o | output | DATA_W | Holding register |
| ninth_o | output | 1 | Ninth received bit |
| done_o | output | 1 | Receive-complete flag |
| ovr_o | output | 1 | Overrun error |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The holding register and the receive-complete flag are due on the third system clock edge after a rising `sck`. The bench drives all inputs on the falling clock edge and samples outputs there too. In one case it counts falling edges to confirm the flag is still low after the second edge and high after the third. Read strobes and enable changes take effect on the next rising edge, so their results are checked one falling edge later. Serial bits are held long enough that every word-level check happens well after that three-edge latency.

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int DATA_W   = 8,
  parameter bit SCK_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_slave,
  input  logic              cont_en,
  input  logic              single_en,
  input  logic              nine_bit,
  input  logic              rx_ie,
  input  logic              low_power,
  input  logic              sck,
  input  logic              sdi,
  input  logic              rd_data,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o,
  output logic              done_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(DATA_W);

  logic [2:0]        sck_q;
  logic [1:0]        sdi_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shf;
  logic              rx_req, rx_on, sck_edge, bit_in, busy, last;

  assign rx_req   = cont_en | (single_en & ~clk_slave);
  assign rx_on    = port_en & sync_mode & clk_slave & rx_req;
  assign sck_edge = SCK_RISE ? (sck_q[1] & ~sck_q[2]) : (~sck_q[1] & sck_q[2]);
  assign bit_in   = sdi_q[1];
  assign busy     = done_o & ~rd_data;
  assign last     = (cnt == (nine_bit ? LAST9 : LAST8));
  assign irq_o    = done_o & rx_ie;
  assign wake_o   = irq_o & low_power;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= '0;
      sdi_q   <= '0;
      cnt     <= '0;
      shf     <= '0;
      data_o  <= '0;
      ninth_o <= 1'b0;
      done_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
      if (rd_data) done_o <= 1'b0;
      if (!cont_en) ovr_o <= 1'b0;
      if (!rx_on) begin
        cnt <= '0;
      end else if (sck_edge && !ovr_o) begin
        if (last) begin
          cnt <= '0;
          if (busy) begin
            ovr_o <= 1'b1;
          end else begin
            done_o <= 1'b1;
            if (nine_bit) begin
              data_o  <= shf;
              ninth_o <= bit_in;
            end else begin
              data_o  <= {bit_in, shf[DATA_W-1:1]};
              ninth_o <= 1'b0;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
          shf <= {bit_in, shf[DATA_W-1:1]};
        end
      end
    end
  end
endmodule

module sync_slave_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              sync_mode,
  input logic              clk_slave,
  input logic              cont_en,
  input logic              rx_ie,
  input logic              low_power,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o,
  input logic              ovr_o,
  input logic              irq_o,
  input logic              wake_o
);
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && sync_mode && clk_slave && cont_en) |=> ($stable(data_o) && !$rose(done_o)));

  a_r8_ovr_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> $stable(data_o));

  a_r8_ovr_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> $past(done_o));

  a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> !ovr_o);

  a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (done_o && low_power));

  a_r6_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> rx_ie);
endmodule

bind sync_slave_rx sync_slave_rx_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/sync_slave_rx_tb.sv
`timescale 1ns/1ps
module sync_slave_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 0, sync_mode = 0, clk_slave = 0, cont_en = 0, single_en = 0;
  logic nine_bit = 0, rx_ie = 0, low_power = 0, sck = 0, sdi = 0, rd_data = 0;
  logic [7:0] data_o;
  logic ninth_o, done_o, ovr_o, irq_o, wake_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sync_slave_rx dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdi = b; tick(2); sck = 1'b1; tick(4); sck = 1'b0; tick(2);
  endtask

  task automatic send_word(logic [8:0] v, int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic do_read;
    rd_data = 1'b1; tick(1); rd_data = 1'b0;
  endtask

  task automatic enable_all;
    port_en = 1; sync_mode = 1; clk_slave = 1; cont_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    check("R10 data", data_o, 0);
    check("R10 done", done_o, 0);
    check("R10 ovr", ovr_o, 0);
    check("R10 irq", irq_o, 0);
    check("R10 wake", wake_o, 0);

    enable_all;
    tick(2);
    send_word(9'h0A5, 7);
    sdi = 1'b1; tick(2); sck = 1'b1;
    tick(2);
    check("R11 done after 2 edges", done_o, 0);
    tick(1);
    check("R11 done after 3 edges", done_o, 1);
    check("R11 data", data_o, 8'hA5);
    tick(3); sck = 1'b0; tick(2);
    do_read;

    for (int v = 0; v < 256; v++) begin
      rx_ie = v[0];
      send_word(9'(v), 8);
      check("R3 data", data_o, v);
      check("R3 done", done_o, 1);
      check("R3 ninth", ninth_o, 0);
      check("R6 irq", irq_o, v[0]);
      do_read;
      check("R5 done cleared", done_o, 0);
      check("R6 irq cleared", irq_o, 0);
    end

    nine_bit = 1;
    for (int v = 0; v < 512; v++) begin
      send_word(9'(v), 9);
      check("R4 data", data_o, v & 8'hFF);
      check("R4 ninth", ninth_o, (v >> 8) & 1);
      do_read;
    end
    nine_bit = 0;

    send_word(9'h03C, 8);
    check("R8 first word", data_o, 8'h3C);
    send_word(9'h0C3, 8);
    check("R8 ovr set", ovr_o, 1);
    check("R8 old word kept", data_o, 8'h3C);
    send_word(9'h055, 8);
    check("R8 shifting stopped", data_o, 8'h3C);
    check("R8 ovr held", ovr_o, 1);
    cont_en = 0; tick(1);
    check("R9 ovr cleared", ovr_o, 0);
    check("R9 done kept", done_o, 1);
    do_read; cont_en = 1;
    send_word(9'h09E, 8);
    check("R9 receive after clear", data_o, 8'h9E);
    check("R9 no ovr", ovr_o, 0);
    do_read;

    send_word(9'h1FF, 3);
    cont_en = 0; tick(2); cont_en = 1;
    send_word(9'h061, 8);
    check("R9 realigned", data_o, 8'h61);
    do_read;

    for (int k = 0; k < 4; k++) begin
      port_en = (k != 0); sync_mode = (k != 1); clk_slave = (k != 2); cont_en = (k != 3);
      send_word(9'h0F0, 8);
      check("R1 no done", done_o, 0);
      check("R1 data held", data_o, 8'h61);
      enable_all;
    end

    cont_en = 0; single_en = 1;
    send_word(9'h012, 8);
    check("R2 single ignored", done_o, 0);
    check("R2 data held", data_o, 8'h61);
    cont_en = 1;
    send_word(9'h0B7, 4);
    single_en = 0;
    send_word(9'h00B, 4);
    check("R2 cont receives", data_o, 8'hB7);
    do_read;

    low_power = 1; rx_ie = 1;
    send_word(9'h0D2, 8);
    check("R7 data in low power", data_o, 8'hD2);
    check("R7 wake", wake_o, 1);
    rx_ie = 0; tick(1);
    check("R7 wake gated", wake_o, 0);
    do_read;
    low_power = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule